// File: doc/BRIEF.md
# Stereo Serial Audio Word Transmitter

This block takes a stereo pair of 24-bit two's-complement samples and shifts it out on one serial data line. The bit clock and word-select clock are supplied from outside, either by a local clock generator or by an external master. A format input picks between the one-bit-delayed I2S alignment and left-justified alignment. The block samples both clocks with a faster system clock and moves its data output only after a falling edge of the bit clock. This keeps the line stable around the rising edge, where a receiver captures it.

An upstream producer presents a left and right word with a one-cycle valid strobe, and the block keeps that pair in a holding register. At the start of each left half-frame it moves the held pair into its output words and pulses a taken strobe. If no fresh pair has arrived, it sends the previous pair again and pulses an underrun strobe. A slot counter restarts on every word-select transition, so half-frames of 24 or 32 bit clocks (frames of 48 or 64) work without any setting.

Top module: `i2s_lj_tx`

## Requirements
- R1: Each channel word goes out most significant bit (bit 23) first, down to bit 0, one bit per bit-clock slot.
- R2: The left word fills the first half-frame of a frame and the right word the second.
- R3: With `fmt_lj` = 1 (left-justified), the left half-frame is the one with `lrck` high, and bit 23 is in slot 0, the first slot after the `lrck` transition.
- R4: With `fmt_lj` = 0 (I2S), the left half-frame is the one with `lrck` low, and bit 23 is in slot 1, one bit clock after the transition.
- R5: `sdout` changes only in the system-clock cycle after a falling `sclk` edge is seen, and it holds while `sclk` is high.
- R6: Slots after bit 0 in a half-frame are driven 0.
- R7: Half-frames of 24 and 32 slots both work with no configuration, because every `lrck` transition restarts the slot count at 0.
- R8: In I2S mode, when the previous half-frame had only 24 slots, slot 0 carries bit 0 of that previous word. After a 32-slot half-frame, slot 0 is 0.
- R9: A pair presented with `in_valid` is moved into the output words at the start of the next left half-frame, and `taken` pulses for one cycle there.
- R10: If no pair has arrived since the last left half-frame started, the previous pair is sent again and `underrun` pulses for one cycle instead of `taken`.
- R11: After reset, `sdout`, `taken` and `underrun` are 0 and both held words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples `sclk` and `lrck` |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_lj | input | 1 | 1 = left-justified, 0 = I2S |
| sclk | input | 1 | Serial bit clock |
| lrck | input | 1 | Word-select clock |
| in_valid | input | 1 | One-cycle strobe: `in_left`/`in_right` hold a new pair |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| sdout | output | 1 | Serial data |
| taken | output | 1 | One-cycle pulse when a fresh pair is loaded |
| underrun | output | 1 | One-cycle pulse when the previous pair is reused |

## Verification
On every cycle, the checks confirm four things: the data line moves only just after a falling bit-clock edge, the taken and underrun strobes never fire together, each strobe lasts a single cycle, and a strobe appears only at a falling bit-clock edge while the left word-select level is present. Other behaviour can only be shown by the bench scenarios. This covers the bit order, the one-slot delay against no delay, zero padding, the carried least significant bit in 48-slot I2S frames, switching between frame lengths and formats, and the repeat-on-underrun behaviour. For these the bench plays the receiver and compares every slot against the words queued by its driver.

// File: rtl/i2s_lj_tx.sv
module i2s_lj_tx #(
  parameter int WORD_W = 24,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_lj,
  input  logic              sclk,
  input  logic              lrck,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  output logic              sdout,
  output logic              taken,
  output logic              underrun
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [SLOT_W-1:0] SLOT_MAX  = '1;
  localparam logic [SLOT_W-1:0] LAST_FULL = SLOT_W'(WORD_W - 1);
  localparam logic [SLOT_W:0]   WORD_LIM  = (SLOT_W+1)'(WORD_W);

  logic              sclk_q, lrck_q, hold_full;
  logic [SLOT_W-1:0] slot, slot_n;
  logic [WORD_W-1:0] wl, wr, hold_l, hold_r;

  wire fall       = sclk_q & ~sclk;
  wire lr_edge    = fall & (lrck != lrck_q);
  wire is_left    = fmt_lj ? lrck : ~lrck;
  wire left_start = lr_edge & is_left;

  wire [WORD_W-1:0] ld_l   = hold_full ? hold_l : wl;
  wire [WORD_W-1:0] ld_r   = hold_full ? hold_r : wr;
  wire [WORD_W-1:0] cur_w  = is_left ? (left_start ? ld_l : wl) : wr;
  wire [WORD_W-1:0] prev_w = is_left ? wr : wl;

  assign slot_n = lr_edge ? '0 : (slot == SLOT_MAX ? slot : slot + 1'b1);

  wire [SLOT_W:0] pos = {1'b0, slot_n} - {{SLOT_W{1'b0}}, ~fmt_lj};
  wire [SLOT_W:0] sel = WORD_LIM - 1'b1 - pos;

  logic bit_n;
  always_comb begin
    if (!fmt_lj && lr_edge)
      bit_n = (slot == LAST_FULL) ? prev_w[0] : 1'b0;
    else if (pos < WORD_LIM)
      bit_n = cur_w[sel[IDX_W-1:0]];
    else
      bit_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      lrck_q    <= 1'b0;
      slot      <= SLOT_MAX;
      sdout     <= 1'b0;
      wl        <= '0;
      wr        <= '0;
      hold_l    <= '0;
      hold_r    <= '0;
      hold_full <= 1'b0;
      taken     <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      sclk_q   <= sclk;
      taken    <= left_start & hold_full;
      underrun <= left_start & ~hold_full;
      if (fall) begin
        lrck_q <= lrck;
        slot   <= slot_n;
        sdout  <= bit_n;
      end
      if (left_start) begin
        wl <= ld_l;
        wr <= ld_r;
      end
      if (in_valid) begin
        hold_l    <= in_left;
        hold_r    <= in_right;
        hold_full <= 1'b1;
      end else if (left_start) begin
        hold_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2s_lj_tx_chk.sv
module i2s_lj_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic fmt_lj,
  input logic sclk,
  input logic lrck,
  input logic sdout,
  input logic taken,
  input logic underrun
);
  // R5
  sdout_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> ($past(sclk, 2) && !$past(sclk)));

  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, underrun}));

  // R9
  taken_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> !taken);

  // R10
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  // R9
  strobe_left_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken || underrun) |-> ($past(fmt_lj) ? $past(lrck) : !$past(lrck)));

  // R5
  strobe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken || underrun) |-> ($past(sclk, 2) && !$past(sclk)));
endmodule

bind i2s_lj_tx i2s_lj_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj), .sclk(sclk), .lrck(lrck),
  .sdout(sdout), .taken(taken), .underrun(underrun)
);

// File: tb/i2s_lj_tx_tb.sv
module i2s_lj_tx_tb;
  logic clk = 0, rst_n = 0, fmt_lj = 1, sclk = 1, lrck = 0, in_valid = 0;
  logic [23:0] in_left = '0, in_right = '0;
  logic sdout, taken, underrun;

  int checks = 0, errors = 0, n_tk = 0, n_ur = 0, prev_len = 32;
  logic [47:0] sb[$];
  logic [23:0] cur_l = '0, cur_r = '0, prev_w = '0;

  i2s_lj_tx u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj), .sclk(sclk), .lrck(lrck),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .sdout(sdout), .taken(taken), .underrun(underrun)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (taken) n_tk++;
    if (underrun) n_ur++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic offer(logic [23:0] l, logic [23:0] r);
    @(negedge clk);
    in_valid = 1; in_left = l; in_right = r;
    sb.push_back({l, r});
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic exp_bit(bit lj, int k, logic [23:0] w,
                                   logic [23:0] pw, int plen);
    if (lj) return (k < 24) ? w[23-k] : 1'b0;
    if (k == 0) return (plen == 24) ? pw[0] : 1'b0;
    return (k <= 24) ? w[24-k] : 1'b0;
  endfunction

  function automatic string tag_for(bit lj, int k);
    if (lj) return (k == 0) ? "R3 msb slot0" : (k < 24 ? "R1 bit" : "R6 pad");
    if (k == 0) return "R8 carried lsb";
    if (k == 1) return "R4 msb slot1";
    return (k <= 24) ? "R1 bit" : "R6 pad";
  endfunction

  task automatic half(bit lv, int len, logic [23:0] w, bit do_chk, string side);
    for (int k = 0; k < len; k++) begin
      logic mid;
      logic e;
      e = exp_bit(fmt_lj, k, w, prev_w, prev_len);
      @(negedge clk); sclk = 0; lrck = lv;
      repeat (2) @(negedge clk);
      mid = sdout;
      repeat (2) @(negedge clk);
      sclk = 1;
      if (do_chk) begin
        chk($sformatf("%s %s%s k=%0d", tag_for(fmt_lj, k), side,
                      (len == 24) ? " R7" : "", k), {31'd0, sdout}, {31'd0, e});
        chk($sformatf("R5 hold %s k=%0d", side, k), {31'd0, sdout}, {31'd0, mid});
      end
      repeat (3) @(negedge clk);
    end
    prev_w = w;
    prev_len = len;
  endtask

  task automatic frame(int len);
    bit lvl;
    bit exp_ur;
    int tk0, ur0;
    lvl = fmt_lj;
    if (lrck == lvl) half(!lvl, 32, cur_r, 0, "warmup");
    exp_ur = (sb.size() == 0);
    if (!exp_ur) {cur_l, cur_r} = sb.pop_front();
    tk0 = n_tk; ur0 = n_ur;
    half(lvl, len, cur_l, 1, "R2 left");
    chk("R9 taken pulses", n_tk - tk0, exp_ur ? 0 : 1);
    chk("R10 underrun pulses", n_ur - ur0, exp_ur ? 1 : 0);
    half(!lvl, len, cur_r, 1, "R2 right");
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset sdout", {31'd0, sdout}, 0);
    chk("R11 reset taken", {31'd0, taken}, 0);
    chk("R11 reset underrun", {31'd0, underrun}, 0);

    offer(24'hA5C3F1, 24'h5A3C0F);
    frame(32);
    offer(24'h800001, 24'h7FFFFE);
    frame(24);
    frame(24);
    frame(32);

    fmt_lj = 0;
    offer(24'hC0FFEE, 24'h123457);
    frame(32);
    offer(24'hFFFFFF, 24'h000001);
    frame(24);
    frame(24);
    offer(24'h0F0F0F, 24'hF0F0F1);
    frame(32);

    fmt_lj = 1;
    offer(24'h96A55B, 24'h3C3C3D);
    frame(24);
    finish_run();
  end
endmodule